// File: doc/BRIEF.md
# Sixteen-bit PWM compare channel with shadow reload

This block is one output channel of a pulse-width modulator. It watches a shared, free-running 16-bit timebase. The timebase is built elsewhere and reaches the channel as a count value with an advance strobe. The channel drives its output high when the count reaches the compare value and low when the count wraps back to zero. The compare value therefore sets the low time of each period, and the duty cycle is (65536 − compare)/65536.

Software reaches the channel through a small byte-wide register port. The compare value is written as two bytes at two addresses. A select bit in the status register decides whether those two addresses reach the live compare register or a shadow reload register. While the mode is active, the shadow is copied into the live compare on every wrap, so a new duty cycle written at any time takes effect cleanly at the next period. A low-byte write to the live compare clears the channel enable and a high-byte write sets it again, so a two-byte update cannot produce a half-formed value. The channel keeps a sticky match flag and a sticky wrap flag, and raises an interrupt request from the match flag.

Top module: `pwm16_chan`

## Requirements
- R1: With the mode active, the output is high in the cycle after a cycle in which the advance strobe is 1 and the count equals the compare value in effect.
- R2: The output is low in the cycle after an advance with count 0x0000 (a wrap), unless that same advance is also a match.
- R3: The mode is active only when control register (address 0) bits 0 (compare enable), 1 (PWM enable) and 2 (16-bit select) are all 1. Otherwise the output is low and no match is detected.
- R4: Status register (address 1) bit 2 selects the value path. When it is 1, addresses 2 (low byte) and 3 (high byte) read and write the shadow reload register. When it is 0, they reach the live compare register. Shadow writes leave the control bits untouched.
- R5: On a wrap while the mode is active, the shadow value is copied into the live compare, and the match test on that same wrap already uses the copied value.
- R6: A write to address 2 on the live path clears control bit 0. A write to address 3 on the live path sets control bit 0.
- R7: When control bit 0 is 0, the output is low in the same cycle, giving a 0% duty cycle.
- R8: A compare value of 0x0000 keeps the output high through every period. A compare value of 0xFFFF makes it high only for the count 0xFFFF.
- R9: When control bit 3 is 1, each match sets status bit 0 (match flag). When control bit 3 is 0, a match leaves it unchanged.
- R10: Every wrap sets status bit 1 (wrap flag), whether or not the mode is active.
- R11: Writing 0 to status bit 0 or bit 1 clears that flag. Writing 1 leaves it as it was.
- R12: The interrupt request is high exactly while status bit 0 and control bit 4 (interrupt enable) are both 1.
- R13: After reset, all four registers read 0 and the output and the interrupt request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tb_cnt_i | input | 16 | Value of the shared timebase count |
| tb_adv_i | input | 1 | The timebase has advanced to tb_cnt_i in this cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 value low, 3 value high |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i, combinational |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Match interrupt request |

## Verification
The output is checked over count sequences that straddle the wrap, at several compare values. A mid-range value separates rising on match from falling on wrap. The value 0 exposes the tie between match and wrap on the same count. The value 0xFFFF checks the one-count high pulse. The shadow path is tested by loading a new value through the select bit and watching the change appear only after the next wrap. Split byte writes on the live path show the enable dropping and returning. Separate runs with each mode bit cleared, and with the flag enable off, separate gating of the output from flag setting.

// File: rtl/pwm16_pkg.sv
`timescale 1ns/1ps
package pwm16_pkg;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_STAT = 2'd1,
      RA_VLO  = 2'd2,
      RA_VHI  = 2'd3
   } reg_addr_e;

   // Control register, bit 0 is cmp_en
   typedef struct packed {
      logic irq_en;
      logic flag_en;
      logic wide;
      logic pwm_en;
      logic cmp_en;
   } ctrl_t;

   localparam int CTRL_W   = $bits(ctrl_t);
   localparam int ST_MATCH = 0;
   localparam int ST_WRAP  = 1;
   localparam int ST_SEL   = 2;

endpackage

// File: rtl/pwm16_regs.sv
`timescale 1ns/1ps
module pwm16_regs
   import pwm16_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [1:0]        addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   input  logic              load_i,
   input  logic              match_flag_i,
   input  logic              wrap_flag_i,
   output ctrl_t             ctrl_o,
   output logic [CNT_W-1:0]  cmp_o,
   output logic [CNT_W-1:0]  rld_o,
   output logic              clr_match_o,
   output logic              clr_wrap_o
);

   if (BYTE_W < 8) begin : g_bad_width
      $error("pwm16_regs: BYTE_W must be at least 8");
   end

   ctrl_t            ctrl_q;
   logic             sel_q;
   logic [CNT_W-1:0] cmp_q, cmp_nx;
   logic [CNT_W-1:0] rld_q, rld_nx;
   logic             wr_ctrl, wr_stat, wr_lo_live, wr_hi_live;

   assign wr_ctrl    = we_i && (addr_i == RA_CTRL);
   assign wr_stat    = we_i && (addr_i == RA_STAT);
   assign wr_lo_live = we_i && (addr_i == RA_VLO) && !sel_q;
   assign wr_hi_live = we_i && (addr_i == RA_VHI) && !sel_q;

   // One byte lane per half of the value registers
   for (genvar l = 0; l < 2; l++) begin : g_lane
      localparam logic [1:0] LANE_ADDR = 2'(2 + l);
      logic lane_wr;
      assign lane_wr = we_i && (addr_i == LANE_ADDR);
      assign cmp_nx[l*BYTE_W +: BYTE_W] =
         load_i              ? rld_q[l*BYTE_W +: BYTE_W] :
         (lane_wr && !sel_q) ? wdata_i :
                               cmp_q[l*BYTE_W +: BYTE_W];
      assign rld_nx[l*BYTE_W +: BYTE_W] =
         (lane_wr && sel_q) ? wdata_i : rld_q[l*BYTE_W +: BYTE_W];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         sel_q  <= 1'b0;
         cmp_q  <= '0;
         rld_q  <= '0;
      end else begin
         cmp_q <= cmp_nx;
         rld_q <= rld_nx;
         if (wr_stat) sel_q <= wdata_i[ST_SEL];
         if (wr_ctrl)         ctrl_q        <= ctrl_t'(wdata_i[CTRL_W-1:0]);
         else if (wr_lo_live) ctrl_q.cmp_en <= 1'b0;
         else if (wr_hi_live) ctrl_q.cmp_en <= 1'b1;
      end
   end

   assign clr_match_o = wr_stat && !wdata_i[ST_MATCH];
   assign clr_wrap_o  = wr_stat && !wdata_i[ST_WRAP];
   assign ctrl_o      = ctrl_q;
   assign cmp_o       = cmp_q;
   assign rld_o       = rld_q;

   always_comb begin
      rdata_o = '0;
      case (reg_addr_e'(addr_i))
         RA_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
         RA_STAT: begin
            rdata_o[ST_MATCH] = match_flag_i;
            rdata_o[ST_WRAP]  = wrap_flag_i;
            rdata_o[ST_SEL]   = sel_q;
         end
         RA_VLO:  rdata_o = sel_q ? rld_q[BYTE_W-1:0] : cmp_q[BYTE_W-1:0];
         RA_VHI:  rdata_o = sel_q ? rld_q[CNT_W-1:BYTE_W] : cmp_q[CNT_W-1:BYTE_W];
         default: rdata_o = '0;
      endcase
   end

   // R6: a live low-byte write drops the enable
   assert_lo_clears_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_lo_live |=> !ctrl_o.cmp_en);

   // R6: a live high-byte write raises the enable
   assert_hi_sets_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hi_live |=> ctrl_o.cmp_en);

   // R5: a wrap while active copies the shadow into the live compare
   assert_reload_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (cmp_o == $past(rld_o)));

   // R4: shadow-path writes leave the live compare alone
   assert_shadow_isolated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_q && !load_i) |=> (cmp_o == $past(cmp_o)));

endmodule

// File: rtl/pwm16_evt.sv
`timescale 1ns/1ps
module pwm16_evt #(
   parameter int CNT_W = 16
) (
   input  logic             active_i,
   input  logic             adv_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic [CNT_W-1:0] rld_i,
   output logic             wrap_o,
   output logic             load_o,
   output logic             match_o
);

   logic [CNT_W-1:0] cmp_eff;

   assign wrap_o  = adv_i && (cnt_i == '0);
   assign load_o  = active_i && wrap_o;
   // On the wrap that reloads, the new value already decides the match
   assign cmp_eff = load_o ? rld_i : cmp_i;
   assign match_o = active_i && adv_i && (cnt_i == cmp_eff);

endmodule

// File: rtl/pwm16_core.sv
`timescale 1ns/1ps
module pwm16_core
   import pwm16_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  active_i,
   input  ctrl_t ctrl_i,
   input  logic  wrap_i,
   input  logic  match_i,
   input  logic  clr_match_i,
   input  logic  clr_wrap_i,
   output logic  match_flag_o,
   output logic  wrap_flag_o,
   output logic  pwm_o,
   output logic  irq_o
);

   logic out_q, match_flag_q, wrap_flag_q;
   logic set_match;

   assign set_match = match_i && ctrl_i.flag_en;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q        <= 1'b0;
         match_flag_q <= 1'b0;
         wrap_flag_q  <= 1'b0;
      end else begin
         if (!active_i)    out_q <= 1'b0;
         else if (match_i) out_q <= 1'b1;
         else if (wrap_i)  out_q <= 1'b0;

         if (set_match)        match_flag_q <= 1'b1;
         else if (clr_match_i) match_flag_q <= 1'b0;

         if (wrap_i)          wrap_flag_q <= 1'b1;
         else if (clr_wrap_i) wrap_flag_q <= 1'b0;
      end
   end

   assign pwm_o        = out_q && active_i;
   assign irq_o        = match_flag_q && ctrl_i.irq_en;
   assign match_flag_o = match_flag_q;
   assign wrap_flag_o  = wrap_flag_q;

   // R1: a match drives the output high
   assert_rise_on_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i |=> out_q);

   // R2: a wrap that is not also a match drives it low
   assert_fall_on_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap_i && !match_i) |=> !out_q);

   // R9: an enabled match sets the sticky flag
   assert_match_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_match |=> match_flag_o);

   // R10: every wrap sets the wrap flag
   assert_wrap_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_i |=> wrap_flag_o);

   // R11: a clear with no concurrent set empties the match flag
   assert_clear_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_match_i && !set_match) |=> !match_flag_o);

endmodule

// File: rtl/pwm16_chan.sv
`timescale 1ns/1ps
module pwm16_chan
   import pwm16_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CNT_W-1:0]  tb_cnt_i,
   input  logic              tb_adv_i,
   input  logic              reg_we_i,
   input  logic [1:0]        reg_addr_i,
   input  logic [BYTE_W-1:0] reg_wdata_i,
   output logic [BYTE_W-1:0] reg_rdata_o,
   output logic              pwm_o,
   output logic              irq_o
);

   ctrl_t            ctrl;
   logic [CNT_W-1:0] cmp, rld;
   logic             active, wrap, load, match;
   logic             clr_match, clr_wrap, match_flag, wrap_flag;

   assign active = ctrl.cmp_en && ctrl.pwm_en && ctrl.wide;

   pwm16_regs #(.BYTE_W(BYTE_W)) regs_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .we_i         (reg_we_i),
      .addr_i       (reg_addr_i),
      .wdata_i      (reg_wdata_i),
      .rdata_o      (reg_rdata_o),
      .load_i       (load),
      .match_flag_i (match_flag),
      .wrap_flag_i  (wrap_flag),
      .ctrl_o       (ctrl),
      .cmp_o        (cmp),
      .rld_o        (rld),
      .clr_match_o  (clr_match),
      .clr_wrap_o   (clr_wrap)
   );

   pwm16_evt #(.CNT_W(CNT_W)) evt_i (
      .active_i (active),
      .adv_i    (tb_adv_i),
      .cnt_i    (tb_cnt_i),
      .cmp_i    (cmp),
      .rld_i    (rld),
      .wrap_o   (wrap),
      .load_o   (load),
      .match_o  (match)
   );

   pwm16_core core_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .active_i     (active),
      .ctrl_i       (ctrl),
      .wrap_i       (wrap),
      .match_i      (match),
      .clr_match_i  (clr_match),
      .clr_wrap_i   (clr_wrap),
      .match_flag_o (match_flag),
      .wrap_flag_o  (wrap_flag),
      .pwm_o        (pwm_o),
      .irq_o        (irq_o)
   );

endmodule

// File: tb/pwm16_chan_tb_top.sv
`timescale 1ns/1ps
module pwm16_chan_tb_top;

   localparam int BW = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cnt = '0;
   logic          adv = 1'b0;
   logic          we = 1'b0;
   logic [1:0]    addr = '0;
   logic [BW-1:0] wd = '0;
   logic [BW-1:0] rd;
   logic          pwm, irq;

   always #10 clk = ~clk;

   pwm16_chan #(.BYTE_W(BW)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tb_cnt_i    (cnt),
      .tb_adv_i    (adv),
      .reg_we_i    (we),
      .reg_addr_i  (addr),
      .reg_wdata_i (wd),
      .reg_rdata_o (rd),
      .pwm_o       (pwm),
      .irq_o       (irq)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   string cur_tag = "R13";

   // Requirement-level model
   logic [CW-1:0] m_cmp, m_rld;
   logic [4:0]    m_ctrl;
   logic          m_sel, m_mf, m_of, m_out;

   // Scoreboard queues
   int    dq[$];
   bit    pq[$];
   bit    iq[$];
   string tq[$];

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor: compares each expected item in the cycle it falls due
   always @(negedge clk) begin
      while (dq.size() > 0 && dq[0] <= cyc) begin
         int    d;
         bit    ep, ei;
         string t;
         d  = dq.pop_front();
         ep = pq.pop_front();
         ei = iq.pop_front();
         t  = tq.pop_front();
         if (d == cyc) begin
            check({t, " pwm"}, 16'(pwm), 16'(ep));
            check({t, " irq R12"}, 16'(irq), 16'(ei));
         end
      end
   end

   // Driver: one clock of stimulus, model update, expected item push
   task automatic cycle(bit a, logic [CW-1:0] c, bit w, logic [1:0] ad, logic [BW-1:0] d);
      bit act, wrap, load, mt, nout, nmf, nof;
      logic [CW-1:0] ceff, ncmp;
      @(posedge clk);
      #2;
      adv = a; cnt = c; we = w; addr = ad; wd = d;
      act  = m_ctrl[0] && m_ctrl[1] && m_ctrl[2];
      wrap = a && (c == 0);
      load = act && wrap;
      ceff = load ? m_rld : m_cmp;
      mt   = act && a && (c == ceff);
      nout = !act ? 1'b0 : mt ? 1'b1 : wrap ? 1'b0 : m_out;
      nmf  = (mt && m_ctrl[3]) ? 1'b1 : (w && ad == 2'd1 && !d[0]) ? 1'b0 : m_mf;
      nof  = wrap ? 1'b1 : (w && ad == 2'd1 && !d[1]) ? 1'b0 : m_of;
      ncmp = m_cmp;
      if (w) begin
         case (ad)
            2'd0: m_ctrl = d[4:0];
            2'd1: m_sel = d[2];
            2'd2: if (m_sel) m_rld[7:0] = d; else begin ncmp[7:0] = d; m_ctrl[0] = 1'b0; end
            default: if (m_sel) m_rld[15:8] = d; else begin ncmp[15:8] = d; m_ctrl[0] = 1'b1; end
         endcase
      end
      if (load) ncmp = ceff;
      m_cmp = ncmp; m_out = nout; m_mf = nmf; m_of = nof;
      dq.push_back(cyc + 1);
      pq.push_back(m_out && m_ctrl[0] && m_ctrl[1] && m_ctrl[2]);
      iq.push_back(m_mf && m_ctrl[4]);
      tq.push_back(cur_tag);
   endtask

   task automatic wr(logic [1:0] a, logic [BW-1:0] d);
      cycle(1'b0, '0, 1'b1, a, d);
   endtask

   task automatic step(logic [CW-1:0] c);
      cycle(1'b1, c, 1'b0, 2'd0, '0);
   endtask

   task automatic rdc(logic [1:0] a, logic [BW-1:0] exp, string tag);
      cycle(1'b0, '0, 1'b0, a, '0);
      #1;
      check(tag, 16'(rd), 16'(exp));
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      m_cmp = '0; m_rld = '0; m_ctrl = '0; m_sel = 0; m_mf = 0; m_of = 0; m_out = 0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #1;
      // R13: reset state
      check("R13 pwm", 16'(pwm), 16'h0);
      check("R13 irq", 16'(irq), 16'h0);
      rdc(2'd0, 8'h00, "R13 ctrl");
      rdc(2'd1, 8'h00, "R13 status");
      rdc(2'd2, 8'h00, "R13 value low");
      rdc(2'd3, 8'h00, "R13 value high");

      // R4: shadow path through the select bit
      cur_tag = "R4";
      wr(2'd0, 8'h0F);
      rdc(2'd0, 8'h0F, "R3 ctrl write");
      wr(2'd1, 8'h04);
      rdc(2'd1, 8'h04, "R4 select bit");
      wr(2'd2, 8'h03);
      wr(2'd3, 8'h00);
      rdc(2'd0, 8'h0F, "R4 shadow write keeps enable");
      rdc(2'd2, 8'h03, "R4 shadow readback");
      wr(2'd1, 8'h00);
      rdc(2'd2, 8'h00, "R4 live compare untouched");

      // R1/R2/R5: mid-range compare straddling the wrap
      cur_tag = "R1/R2/R5 compare 3";
      step(16'hFFFE); step(16'hFFFF); step(16'h0000);
      step(16'h0001); step(16'h0002); step(16'h0003);
      step(16'h0004); step(16'hFFFF); step(16'h0000);
      rdc(2'd2, 8'h03, "R5 reload copied at wrap");
      rdc(2'd1, 8'h03, "R9/R10 flags set");

      // R12 and R11
      cur_tag = "R12 irq enable";
      wr(2'd0, 8'h1F);
      cur_tag = "R11 clear match";
      wr(2'd1, 8'h02);
      rdc(2'd1, 8'h02, "R11 match flag cleared");
      wr(2'd1, 8'h03);
      rdc(2'd1, 8'h02, "R11 writing 1 has no effect");
      wr(2'd1, 8'h00);
      rdc(2'd1, 8'h00, "R11 wrap flag cleared");
      wr(2'd0, 8'h0F);

      // R8: compare 0 gives full duty
      cur_tag = "R8 compare 0";
      wr(2'd1, 8'h04); wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h00);
      step(16'h1000); step(16'hFFFF); step(16'h0000); step(16'h0001);
      step(16'h8000); step(16'hFFFF); step(16'h0000); step(16'h0002);

      // R8: compare FFFF gives a single-count pulse
      cur_tag = "R8 compare FFFF";
      wr(2'd1, 8'h04); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); wr(2'd1, 8'h00);
      step(16'h0000); step(16'h0005); step(16'hFFFE);
      step(16'hFFFF); step(16'h0000); step(16'h0001);

      // R7/R6: live byte writes drop and restore the enable
      cur_tag = "R7 enable cleared";
      wr(2'd1, 8'h04); wr(2'd2, 8'h00); wr(2'd3, 8'h01); wr(2'd1, 8'h00);
      step(16'h0000); step(16'h0100); step(16'h0101);
      wr(2'd2, 8'h55);
      rdc(2'd0, 8'h0E, "R6 low byte clears enable");
      wr(2'd3, 8'h01);
      rdc(2'd0, 8'h0F, "R6 high byte sets enable");
      rdc(2'd2, 8'h55, "R6 live low byte stored");
      cur_tag = "R1 live compare";
      step(16'h0155); step(16'h0000); step(16'h0100);

      // R3: each mode bit gates the output
      cur_tag = "R3 mode gating";
      wr(2'd0, 8'h0B);
      wr(2'd1, 8'h00);
      step(16'h0100); step(16'h0000); step(16'h0100);
      rdc(2'd1, 8'h02, "R3/R10 no match while inactive, wrap flag set");
      wr(2'd0, 8'h0D);
      step(16'h0100); step(16'h0000); step(16'h0100);

      // R9: flag enable off
      cur_tag = "R9 flag enable off";
      wr(2'd0, 8'h07);
      wr(2'd1, 8'h00);
      step(16'h0000); step(16'h0100); step(16'h0101);
      rdc(2'd1, 8'h02, "R9 match flag stays clear");

      repeat (3) cycle(1'b0, '0, 1'b0, 2'd0, '0);
      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1;
      summary();
      $finish;
   end

endmodule